// File: doc/BRIEF.md
# Masked BSSID Receive Filter

This block decides, for each received frame, whether the frame's 48-bit BSSID field belongs to one of the basic service sets served locally, and so whether the frame should be acknowledged. It holds a local station address and a 48-bit selection mask. A frame is accepted when every bit that the mask selects matches the same bit of the local address. Bits that the mask clears are ignored.

Host software loads the address and the mask through a small word-wide register port that has per-byte write enables. Software also computes the mask. For each served BSSID it takes the bits that agree with the local address, then ANDs those results together across all served BSSIDs. In station mode, or with a single BSS, the mask is all ones and the filter requires an exact match. With several virtual BSSes, one comparator serves all of them. The cost is that some foreign BSSIDs that agree on the selected bits are accepted too.

A frame BSSID is presented with a one-cycle valid strobe. One clock later the block returns a registered decision flag together with a valid pulse.

Top module: `bssid_rx_filter`

## Requirements
- R1: One cycle after `frm_valid`, `acc_ok` is 1 exactly when `((frm_bssid ^ mac) & mask) == 0`, using the MAC and mask values held at the strobe's clock edge.
- R2: With the mask all ones, only an exact 48-bit match with the MAC is accepted. A single differing bit at either end of the field causes a reject.
- R3: Register select 0 holds MAC bits [31:0]. Bit 0 of the register is MAC bit 0, and byte lane k maps to MAC bits [8k+7:8k].
- R4: Register select 1 holds MAC bits [47:32] in its bits [15:0] and a 16-bit auxiliary field in bits [31:16]. Each byte lane is written only when its `reg_be` bit is set. A write that enables only lanes 0 and 1 leaves the auxiliary field unchanged.
- R5: Register select 2 holds mask bits [31:0]. Register select 3 holds mask bits [47:32] in bits [15:0], and its bits [31:16] always read 0.
- R6: `acc_valid` is high for exactly the cycle after each cycle in which `frm_valid` is high. `acc_ok` is 0 whenever `acc_valid` is 0.
- R7: After reset, the MAC and auxiliary field are all zeros, the mask is all ones, and `acc_valid` and `acc_ok` are 0.
- R8: A frame strobed in the same cycle as a register write is judged with the values held before that write. The next frame is judged with the new values.
- R9: With MAC low nibble 0001, mask low nibble 0010 and all other mask bits set, frames whose low nibble is 0001, 0100, 1001 or 1101 are accepted and 0110 is rejected. The 1101 accept is the expected false accept.
- R10: `reg_rdata` shows the contents of the register chosen by `reg_addr` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 MAC low, 1 MAC high/aux, 2 mask low, 3 mask high) |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Read data of the selected register |
| frm_valid | input | 1 | Frame BSSID strobe |
| frm_bssid | input | 48 | Frame BSSID field |
| acc_valid | output | 1 | Decision valid, one cycle after the strobe |
| acc_ok | output | 1 | 1 = accept, 0 = reject |

## Verification
A frame decision is due exactly one clock after the edge that samples `frm_valid`. The bench raises the strobe on a falling edge, lets one rising edge pass, and reads `acc_valid` and `acc_ok` on the next falling edge. It then drops the strobe and confirms one cycle later that the pulse has ended.

Register writes take effect at the rising edge that samples `reg_wr`. Read data is combinational, so read-backs are sampled on the falling edge of the cycle in which `reg_addr` is driven.

The same-cycle write-and-frame case checks that the earlier edge's values decide the frame. The sweep covers all 16 × 16 combinations of low-nibble mask and frame, with expected results computed arithmetically.

// File: rtl/bssid_filt_pkg.sv
package bssid_filt_pkg;
    localparam int ADDR_W = 48;
    localparam int WORD_W = 32;
    localparam int LANE_W = 8;
    localparam int HI_W   = ADDR_W - WORD_W;
    localparam int AUX_W  = WORD_W - HI_W;
    localparam int BE_W   = WORD_W / LANE_W;
    localparam int SEL_W  = 2;
    localparam int N_LANE = ADDR_W / LANE_W;

    typedef enum logic [SEL_W-1:0] {
        SEL_MAC_LO = 2'd0,
        SEL_MAC_HI = 2'd1,
        SEL_MSK_LO = 2'd2,
        SEL_MSK_HI = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [ADDR_W-1:0] mac;
        logic [ADDR_W-1:0] mask;
        logic [AUX_W-1:0]  aux;
    } filt_cfg_t;

    function automatic logic [WORD_W-1:0] lane_merge(
        input logic [WORD_W-1:0] old_w,
        input logic [WORD_W-1:0] new_w,
        input logic [BE_W-1:0]   be
    );
        logic [WORD_W-1:0] r;
        r = old_w;
        for (int i = 0; i < BE_W; i++) begin
            if (be[i]) r[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return r;
    endfunction
endpackage

// File: rtl/bssid_cfg_regs.sv
module bssid_cfg_regs
    import bssid_filt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr,
    input  logic [SEL_W-1:0]      addr,
    input  logic [WORD_W-1:0]     wdata,
    input  logic [BE_W-1:0]       be,
    output filt_cfg_t             cfg,
    output logic [WORD_W-1:0]     rdata
);
    filt_cfg_t cfg_q;
    filt_cfg_t cfg_d;
    logic [WORD_W-1:0] cur_word;
    logic [WORD_W-1:0] new_word;

    always_comb begin
        case (reg_sel_e'(addr))
            SEL_MAC_LO: cur_word = cfg_q.mac[WORD_W-1:0];
            SEL_MAC_HI: cur_word = {cfg_q.aux, cfg_q.mac[ADDR_W-1:WORD_W]};
            SEL_MSK_LO: cur_word = cfg_q.mask[WORD_W-1:0];
            default:    cur_word = {{AUX_W{1'b0}}, cfg_q.mask[ADDR_W-1:WORD_W]};
        endcase
    end

    assign new_word = lane_merge(cur_word, wdata, be);

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            case (reg_sel_e'(addr))
                SEL_MAC_LO: cfg_d.mac[WORD_W-1:0] = new_word;
                SEL_MAC_HI: begin
                    cfg_d.mac[ADDR_W-1:WORD_W] = new_word[HI_W-1:0];
                    cfg_d.aux                  = new_word[WORD_W-1:HI_W];
                end
                SEL_MSK_LO: cfg_d.mask[WORD_W-1:0] = new_word;
                default:    cfg_d.mask[ADDR_W-1:WORD_W] = new_word[HI_W-1:0];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.mac  <= '0;
            cfg_q.mask <= '1;
            cfg_q.aux  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg   = cfg_q;
    assign rdata = cur_word;
endmodule

// File: rtl/bssid_masked_cmp.sv
module bssid_masked_cmp
    import bssid_filt_pkg::*;
(
    input  logic [ADDR_W-1:0] bssid,
    input  logic [ADDR_W-1:0] mac,
    input  logic [ADDR_W-1:0] mask,
    output logic              hit
);
    logic [N_LANE-1:0] lane_hit;

    for (genvar g = 0; g < N_LANE; g++) begin : g_lane
        assign lane_hit[g] =
            ((bssid[g*LANE_W +: LANE_W] ^ mac[g*LANE_W +: LANE_W])
              & mask[g*LANE_W +: LANE_W]) == '0;
    end

    assign hit = &lane_hit;
endmodule

// File: rtl/bssid_rx_filter.sv
module bssid_rx_filter
    import bssid_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic [3:0]        reg_be,
    output logic [31:0]       reg_rdata,
    input  logic              frm_valid,
    input  logic [47:0]       frm_bssid,
    output logic              acc_valid,
    output logic              acc_ok
);
    filt_cfg_t          cfg_q;
    logic [ADDR_W-1:0]  cur_mac;
    logic [ADDR_W-1:0]  cur_mask;
    logic [AUX_W-1:0]   cur_aux;
    logic               cmp_hit;
    logic               vld_q;
    logic               ok_q;

    bssid_cfg_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .be    (reg_be),
        .cfg   (cfg_q),
        .rdata (reg_rdata)
    );

    assign cur_mac  = cfg_q.mac;
    assign cur_mask = cfg_q.mask;
    assign cur_aux  = cfg_q.aux;

    bssid_masked_cmp u_cmp (
        .bssid (frm_bssid),
        .mac   (cur_mac),
        .mask  (cur_mask),
        .hit   (cmp_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ok_q  <= 1'b0;
        end else begin
            vld_q <= frm_valid;
            ok_q  <= frm_valid & cmp_hit;
        end
    end

    assign acc_valid = vld_q;
    assign acc_ok    = ok_q;
endmodule

// File: rtl/bssid_rx_filter_chk.sv
module bssid_rx_filter_chk (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [3:0]  reg_be,
    input logic        frm_valid,
    input logic [47:0] frm_bssid,
    input logic        acc_valid,
    input logic        acc_ok,
    input logic [47:0] cfg_mac,
    input logic [47:0] cfg_mask,
    input logic [15:0] cfg_aux
);
    a_r1_masked_decision: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> (acc_ok ==
            ((($past(frm_bssid) ^ $past(cfg_mac)) & $past(cfg_mask)) == 48'h0)));

    a_r2_exact_when_full_mask: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && $past(cfg_mask) == {48{1'b1}}) |->
            (acc_ok == ($past(frm_bssid) == $past(cfg_mac))));

    a_r4_aux_kept: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd1 && reg_be[3:2] == 2'b00) |=> $stable(cfg_aux));

    a_r6_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> acc_valid);

    a_r6_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !frm_valid |=> (!acc_valid && !acc_ok));

    a_r7_reset_state: assert property (@(posedge clk)
        rst |=> (cfg_mask == {48{1'b1}} && cfg_mac == 48'h0 && !acc_valid));

    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ($stable(cfg_mac) && $stable(cfg_mask)));
endmodule

bind bssid_rx_filter bssid_rx_filter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_be    (reg_be),
    .frm_valid (frm_valid),
    .frm_bssid (frm_bssid),
    .acc_valid (acc_valid),
    .acc_ok    (acc_ok),
    .cfg_mac   (cur_mac),
    .cfg_mask  (cur_mask),
    .cfg_aux   (cur_aux)
);

// File: tb/bssid_rx_filter_bench.sv
module bssid_rx_filter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [3:0]  reg_be = 4'h0;
    logic [31:0] reg_rdata;
    logic        frm_valid = 1'b0;
    logic [47:0] frm_bssid = 48'h0;
    logic        acc_valid;
    logic        acc_ok;

    int checks = 0;
    int errors = 0;

    localparam logic [47:0] MAC = 48'hA1B2_C3D4_E5F1;

    always #10 clk = ~clk;

    bssid_rx_filter u_bssid_rx_filter (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
        .frm_valid(frm_valid), .frm_bssid(frm_bssid),
        .acc_valid(acc_valid), .acc_ok(acc_ok)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = 4'h0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(req, {32'h0, reg_rdata}, {32'h0, exp});
    endtask

    task automatic frame(input string req, input logic [47:0] b, input logic exp_ok);
        @(negedge clk);
        frm_valid = 1'b1; frm_bssid = b;
        @(negedge clk);
        frm_valid = 1'b0;
        check(req, {62'h0, acc_valid, acc_ok}, {62'h0, 1'b1, exp_ok});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R7 reset state, R10 combinational reads, R5 upper bits zero
        check("R7 acc", {62'h0, acc_valid, acc_ok}, 64'h0);
        rd_check("R7 mac lo", 2'd0, 32'h0);
        rd_check("R7 mac hi", 2'd1, 32'h0);
        rd_check("R7 mask lo", 2'd2, 32'hFFFF_FFFF);
        rd_check("R5 mask hi", 2'd3, 32'h0000_FFFF);
        // R3 byte lanes in low MAC word
        wr_reg(2'd0, 32'h1122_3344, 4'b0001);
        rd_check("R3 lane0", 2'd0, 32'h0000_0044);
        wr_reg(2'd0, 32'h1122_3344, 4'b1100);
        rd_check("R3 lane23", 2'd0, 32'h1122_0044);
        // R4 aux kept on MAC-high-only write
        wr_reg(2'd1, 32'hBEEF_1234, 4'hF);
        rd_check("R4 full", 2'd1, 32'hBEEF_1234);
        wr_reg(2'd1, 32'h0000_5678, 4'b0011);
        rd_check("R4 aux kept", 2'd1, 32'hBEEF_5678);
        // R5 mask high ignores upper half
        wr_reg(2'd3, 32'hFFFF_FFFF, 4'hF);
        rd_check("R5 hi read", 2'd3, 32'h0000_FFFF);
        // load MAC
        wr_reg(2'd0, MAC[31:0], 4'hF);
        wr_reg(2'd1, {16'hBEEF, MAC[47:32]}, 4'b0011);
        rd_check("R10 mac lo", 2'd0, MAC[31:0]);
        // R2 exact match under full mask
        frame("R2 exact", MAC, 1'b1);
        frame("R2 bit0", MAC ^ 48'h1, 1'b0);
        frame("R2 bit47", MAC ^ (48'h1 << 47), 1'b0);
        // R6 pulse ends
        @(negedge clk);
        check("R6 pulse end", {62'h0, acc_valid, acc_ok}, 64'h0);
        // R9 worked example
        wr_reg(2'd2, 32'hFFFF_FFF2, 4'hF);
        frame("R9 0001", {MAC[47:4], 4'b0001}, 1'b1);
        frame("R9 0100", {MAC[47:4], 4'b0100}, 1'b1);
        frame("R9 1001", {MAC[47:4], 4'b1001}, 1'b1);
        frame("R9 0110", {MAC[47:4], 4'b0110}, 1'b0);
        frame("R9 1101 false accept", {MAC[47:4], 4'b1101}, 1'b1);
        // R1 sweep: all low-nibble masks x frames
        for (int m = 0; m < 16; m++) begin
            wr_reg(2'd2, {28'hFFF_FFFF, 4'(m)}, 4'hF);
            for (int f = 0; f < 16; f++) begin
                frame("R1 sweep", {MAC[47:4], 4'(f)},
                      ((4'(f) ^ MAC[3:0]) & 4'(m)) == 4'h0);
            end
        end
        // R1 upper-bit mismatch masked out
        wr_reg(2'd3, 32'h0000_7FFF, 4'hF);
        frame("R1 masked top", MAC ^ (48'h1 << 47), 1'b1);
        wr_reg(2'd3, 32'h0000_FFFF, 4'hF);
        wr_reg(2'd2, 32'hFFFF_FFFF, 4'hF);
        // R8 write and frame same cycle: old full mask decides
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0; reg_be = 4'hF;
        frm_valid = 1'b1; frm_bssid = MAC ^ 48'h10;
        @(negedge clk);
        reg_wr = 1'b0; frm_valid = 1'b0;
        check("R8 old values", {62'h0, acc_valid, acc_ok}, {62'h0, 2'b10});
        frame("R8 new values", MAC ^ 48'h10, 1'b1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule